// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block gathers the five interrupt causes of a UART channel (receiver line status, received data ready, receive time-out, transmitter holding empty and modem status). It keeps one latched pending flag for each cause and presents the most urgent one as an encoded 8-bit status byte. Each cause arrives as a one-cycle set pulse and is qualified by its own enable bit. The block drives an active-high interrupt request whenever any enabled cause is pending.

Software reads the status byte through a read strobe. The byte on `rd_data_o` is the one captured in the strobe cycle. At the end of that cycle only the cause that the byte named is cleared, so a lower-priority cause shows up on the next read. The top three bits of the byte mirror two configuration inputs: FIFO enable and FIFO depth mode.

Top module: `uart_irq_ident`

## Requirements
- R1: Priority, most urgent first, is: line status (source 0), then data ready (source 1) and receive time-out (source 2) sharing a level, then transmitter empty (source 3), then modem status (source 4).
- R2: Bits 3..0 of the status byte report the winning source as: line status 0110, data ready 0100, receive time-out 1100, transmitter empty 0010, modem status 0000.
- R3: Bit 0 is low-active. With no pending source, bits 3..0 read 0001, and this is also the value after reset.
- R4: When data ready and receive time-out are pending together, data ready (0100) is reported before receive time-out (1100).
- R5: A read clears only the source it reported. Every other pending source stays latched and is reported by later reads in priority order.
- R6: Bits 7 and 6 both equal `fifo_on_i`, bit 5 equals `fifo_deep_i` (1 selects 64-byte mode), and bit 4 is always 0.
- R7: A set pulse for a more urgent source that arrives in a read cycle does not change what that read clears. The new source becomes pending, and the source that was reported is cleared.
- R8: A set pulse for the source that is being cleared by a read in the same cycle wins, and that source stays pending.
- R9: A source whose enable bit is 0 never becomes pending. Dropping an enable bit discards a flag already latched for that source.
- R10: `irq_o` is 1 exactly when at least one enabled source is pending, and it is then the inverse of status bit 0.
- R11: A synchronous reset clears every pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_set_i | input | 5 | One-cycle set pulse per source, bit index = source number |
| src_en_i | input | 5 | Enable per source |
| fifo_on_i | input | 1 | FIFO enable, mirrored into bits 7..6 |
| fifo_deep_i | input | 1 | FIFO depth mode, mirrored into bit 5 |
| rd_i | input | 1 | Status read strobe, one cycle per read |
| rd_data_o | output | 8 | Encoded status byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A status read and a new set pulse can fall in the same clock cycle, and the clear must then hit only the source that the read reported. The bench provokes this in two ways. In the first, a more urgent source is pulsed during a read of a less urgent one; the bench expects the new source on the next read and idle after it. In the second, the source being cleared is pulsed again; the bench expects it to be reported a second time. Every one of the 32 pending patterns is drained read by read against an order that the bench computes from the priority list.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC   = 5;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_IDLE = 4'b0001;

    typedef enum logic [IDX_W-1:0] {
        SRC_LINE  = 3'd0,
        SRC_RXRDY = 3'd1,
        SRC_RXTMO = 3'd2,
        SRC_TXEMP = 3'd3,
        SRC_MODEM = 3'd4
    } src_e;

    function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx);
        case (idx)
            SRC_LINE:  src_code = 4'b0110;
            SRC_RXRDY: src_code = 4'b0100;
            SRC_RXTMO: src_code = 4'b1100;
            SRC_TXEMP: src_code = 4'b0010;
            default:   src_code = 4'b0000;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } flag_st_t;

    flag_st_t     st_d, st_q;
    logic [N-1:0] nxt;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // set beats clear; disabled source drops its flag
        assign nxt[i] = en_i[i] & (set_i[i] | (st_q.flags[i] & ~clr_i[i]));
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]      req_i,
    output logic [N-1:0]      grant_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] win_idx;
    logic          hit;

    always_comb begin
        grant_o = '0;
        win_idx = '0;
        hit     = 1'b0;
        // scan from least to most urgent; the lowest index set wins
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                win_idx    = IW'(i);
                hit        = 1'b1;
            end
        end
        code_o = hit ? src_code(IDX_W'(win_idx)) : CODE_IDLE;
    end
endmodule

// File: rtl/uart_irq_fmt.sv
module uart_irq_fmt
    import uart_irq_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              fifo_on_i,
    input  logic              fifo_deep_i,
    output logic [7:0]        byte_o
);
    always_comb begin
        byte_o                = '0;
        byte_o[CODE_W-1:0]    = code_i;
        byte_o[5]             = fifo_deep_i;
        byte_o[7:6]           = {2{fifo_on_i}};
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_set_i,
    input  logic [NSRC-1:0] src_en_i,
    input  logic            fifo_on_i,
    input  logic            fifo_deep_i,
    input  logic            rd_i,
    output logic [7:0]      rd_data_o,
    output logic            irq_o
);
    logic [NSRC-1:0]   flags_q;
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   grant;
    logic [NSRC-1:0]   clr;
    logic [CODE_W-1:0] code;

    uart_irq_flags #(.N(NSRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (src_set_i),
        .en_i    (src_en_i),
        .clr_i   (clr),
        .flags_o (flags_q)
    );

    assign pend = flags_q & src_en_i;

    uart_irq_prio #(.N(NSRC)) u_prio (
        .req_i   (pend),
        .grant_o (grant),
        .code_o  (code)
    );

    // the read clears only the source named in this cycle's byte
    assign clr = rd_i ? grant : '0;

    uart_irq_fmt u_fmt (
        .code_i      (code),
        .fifo_on_i   (fifo_on_i),
        .fifo_deep_i (fifo_deep_i),
        .byte_o      (rd_data_o)
    );

    assign irq_o = |pend;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uart_irq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] src_set_i,
    input logic [NSRC-1:0] src_en_i,
    input logic            rd_i,
    input logic [7:0]      rd_data_o,
    input logic            irq_o,
    input logic [NSRC-1:0] flags
);
    logic [NSRC-1:0] pend;
    assign pend = flags & src_en_i;

    AST_IRQ_VS_BIT0: assert property (@(posedge clk) disable iff (rst)
        irq_o != rd_data_o[0]); // R10
    AST_CLEAR_TOP: assert property (@(posedge clk) disable iff (rst)
        (rd_i && pend[0] && !src_set_i[0]) |=> !flags[0]); // R5
    AST_KEEP_LOWER: assert property (@(posedge clk) disable iff (rst)
        (rd_i && pend[0] && pend[3] && src_en_i[3]) |=> flags[3]); // R5
    AST_RXRDY_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !pend[0] && pend[1] && pend[2] && src_en_i[2]) |=> flags[2]); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (src_set_i[1] && src_en_i[1]) |=> flags[1]); // R8
    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        !src_en_i[2] |=> !flags[2]); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (flags == '0)); // R11
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_set_i (src_set_i),
    .src_en_i  (src_en_i),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .flags     (flags_q)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] src_set_i = '0;
    logic [4:0] src_en_i = '0;
    logic       fifo_on_i = 1'b0;
    logic       fifo_deep_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    uart_irq_ident uut (
        .clk(clk), .rst(rst), .src_set_i(src_set_i), .src_en_i(src_en_i),
        .fifo_on_i(fifo_on_i), .fifo_deep_i(fifo_deep_i), .rd_i(rd_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic [3:0] nib_of(input logic [4:0] p);
        if (p[0]) return 4'b0110;
        if (p[1]) return 4'b0100;
        if (p[2]) return 4'b1100;
        if (p[3]) return 4'b0010;
        if (p[4]) return 4'b0000;
        return 4'b0001;
    endfunction

    function automatic logic [4:0] drop_top(input logic [4:0] p);
        for (int i = 0; i < 5; i++) if (p[i]) begin p[i] = 1'b0; return p; end
        return p;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [4:0] p);
        return {fifo_on_i, fifo_on_i, fifo_deep_i, 1'b0, nib_of(p)};
    endfunction

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; src_set_i = '0; rd_i = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] s);
        @(negedge clk); src_set_i = s;
        @(negedge clk); src_set_i = '0;
    endtask

    task automatic read_once();
        rd_i = 1'b1;
        @(negedge clk); rd_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [4:0] m;
        do_reset();
        // R3 reset state
        chk("R3 reset byte", rd_data_o, 8'h01);
        chk("R10 reset irq", {7'b0, irq_o}, 8'h00);

        // R1 R2 R5 R6: exhaustive drain of every pending pattern
        src_en_i = 5'h1f;
        for (int p = 0; p < 32; p++) begin
            do_reset();
            fifo_on_i = p[0]; fifo_deep_i = p[2];
            pulse(5'(p));
            m = 5'(p);
            for (int k = 0; k < 6; k++) begin
                chk("R1 R2 R5 R6 drain byte", rd_data_o, exp_byte(m));
                chk("R10 drain irq", {7'b0, irq_o}, {7'b0, m != 0});
                if (m == 0) break;
                read_once();
                m = drop_top(m);
            end
        end
        fifo_on_i = 1'b0; fifo_deep_i = 1'b0;

        // R4 data ready and time-out together
        do_reset();
        pulse(5'b00110);
        chk("R4 first", rd_data_o, 8'h04);
        read_once();
        chk("R4 second", rd_data_o, 8'h0c);

        // R9 enable sweep
        for (int e = 0; e < 32; e++) begin
            do_reset();
            src_en_i = 5'(e);
            pulse(5'h1f);
            src_en_i = 5'h1f;
            chk("R9 gated pending", rd_data_o, exp_byte(5'(e)));
            chk("R9 R10 gated irq", {7'b0, irq_o}, {7'b0, e != 0});
        end
        // R9 dropping an enable discards a latched flag
        do_reset();
        src_en_i = 5'h1f;
        pulse(5'b00011);
        src_en_i = 5'b11110;
        @(negedge clk); src_en_i = 5'h1f;
        chk("R9 drop enable", rd_data_o, 8'h04);

        // R7 more urgent set during a read of tx empty
        do_reset();
        pulse(5'b01000);
        chk("R7 before", rd_data_o, 8'h02);
        src_set_i = 5'b00001; rd_i = 1'b1;
        @(negedge clk); src_set_i = '0; rd_i = 1'b0;
        chk("R7 new source pending", rd_data_o, 8'h06);
        read_once();
        chk("R7 reported one cleared", rd_data_o, 8'h01);

        // R8 set of the cleared source wins
        do_reset();
        pulse(5'b00010);
        src_set_i = 5'b00010; rd_i = 1'b1;
        @(negedge clk); src_set_i = '0; rd_i = 1'b0;
        chk("R8 still pending", rd_data_o, 8'h04);
        read_once();
        chk("R8 cleared later", rd_data_o, 8'h01);

        // R11 reset clears all
        pulse(5'h1f);
        chk("R11 before reset", {7'b0, irq_o}, 8'h01);
        do_reset();
        chk("R11 after reset", rd_data_o, 8'h01);
        chk("R11 irq after reset", {7'b0, irq_o}, 8'h00);

        finish_run();
    end
endmodule